// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array with Row Buffer

This block is a small behavioural model of a DRAM-style memory, seen from the memory controller's side. The storage is a square grid of rows and columns. Each grid position is a supercell of `WIDTH` bits. A single narrow address bus carries the row index and the column index in two separate phases. A row strobe copies one whole row into an internal row buffer. Column strobes then read supercells from that buffer, or write them into it. A precharge writes the buffer back to the array and closes the row. While a row is open, any number of column accesses may use it without a new row strobe.

A free-running interval counter raises a refresh request. The request is served only when no row is open. The refresh loads the next row in turn into the buffer and writes it straight back, and `busy` is high while this happens. Strobes presented while `busy` is high are dropped, and the controller retries them later. A strobe that breaks the protocol raises `proto_err` for one cycle and changes nothing.

The control is a four-state machine:
- `ST_IDLE`: no row open.
- `ST_OPEN`: a row is held in the buffer.
- `ST_REF_RD`: refresh loads a row into the buffer.
- `ST_REF_WB`: refresh writes that row back.

The transitions are:
- `ST_IDLE`→`ST_OPEN` on a lone row strobe.
- `ST_OPEN`→`ST_IDLE` on a lone precharge.
- `ST_IDLE`→`ST_REF_RD` when a refresh is pending. This takes priority over any strobe.
- `ST_REF_RD`→`ST_REF_WB` always.
- `ST_REF_WB`→`ST_IDLE` always.

Top module: `mux_dram`

## Requirements
- R1: After reset, every supercell reads as zero, and `dout_valid`, `proto_err` and `busy` are low.
- R2: A lone `row_stb` at a clock edge with no row open and `busy` low latches `addr` as the row index and loads that whole row into the buffer, which opens the row.
- R3: A lone `col_stb` with `we`=0 on an open row puts the supercell at column `addr` on `dout`. `dout_valid` is high for exactly the one cycle after that edge.
- R4: While a row stays open, further column strobes select other supercells of the same row in any order, with no new row strobe.
- R5: A lone `col_stb` with `we`=1 on an open row writes `din` into the buffer at column `addr`. Later reads of that open row return the new value, and the last write to a cell wins.
- R6: A lone `pre` on an open row writes the buffer back to the array and closes the row, and the written data is returned when the row is opened again. A `pre` with no row open has no effect and raises no error.
- R7: `proto_err` is high for the one cycle after an edge with any of these: `col_stb` with no open row, `row_stb` while a row is open, or more than one of `row_stb`, `col_stb` and `pre` at once. Such an edge gives no `dout_valid` and leaves the open row and its contents unchanged.
- R8: A refresh request is raised every `REF_INTERVAL` clock cycles. With no row open, `busy` goes high the cycle after the request and stays high for exactly 3 cycles, so successive rises are `REF_INTERVAL` cycles apart.
- R9: Each refresh rewrites the next row in turn with its own contents, so stored data survives any number of refreshes.
- R10: Strobes at an edge where `busy` is high are ignored: they cause no `dout_valid`, no `proto_err` and no row opening.
- R11: A refresh request that arrives while a row is open waits and never raises `busy` during that time. It starts right after the precharge, so `busy` is high in the cycle after the precharge edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | IDX_BITS | Shared row/column index |
| row_stb | input | 1 | Row strobe: open row `addr` |
| col_stb | input | 1 | Column strobe: access column `addr` of the open row |
| we | input | 1 | With `col_stb`: 1 = write `din`, 0 = read |
| pre | input | 1 | Precharge: write the buffer back and close the row |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_valid | output | 1 | `dout` holds the result of a read |
| proto_err | output | 1 | The previous edge broke the strobe protocol |
| busy | output | 1 | Refresh active or starting; strobes are ignored |

## Verification
The hardest situations to reach from the ports both involve refresh, because its request comes from an internal counter that the bench cannot trigger directly.

- **Strobes during busy.** The bench polls `busy` on falling edges until a refresh begins. It then drives a column strobe and a row strobe inside that three-cycle window. It confirms they were dropped: no data or error comes out, and a later column strobe reports that no row was opened.
- **Deferred refresh.** The bench holds a row open for longer than a full refresh interval. It checks that `busy` stays low for that whole time and rises right after the precharge.
- **Data survives refresh.** After long idle stretches covering several complete passes over all rows, the bench reads every cell back to confirm the refreshes kept the data.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_REF_RD = 2'd2,
        ST_REF_WB = 2'd3
    } dram_state_e;

endpackage

// File: rtl/mux_dram_cells.sv
// Storage grid: one full-row read port (combinational) and one full-row write port.
module mux_dram_cells #(
    parameter int IDX_BITS = 2,
    parameter int WIDTH    = 8,
    localparam int ROWS    = 1 << IDX_BITS,
    localparam int ROW_W   = ROWS * WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_row,
    output logic [ROW_W-1:0]    rd_data,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_row,
    input  logic [ROW_W-1:0]    wr_data
);

    logic [ROW_W-1:0] rows_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                rows_q[r] <= '0;
            end
        end else if (wr_en) begin
            rows_q[wr_row] <= wr_data;
        end
    end

    assign rd_data = rows_q[rd_row];

endmodule

// File: rtl/mux_dram_rowbuf.sv
// Row buffer: whole-row load, per-column write, registered per-column read.
module mux_dram_rowbuf #(
    parameter int IDX_BITS = 2,
    parameter int WIDTH    = 8,
    localparam int COLS    = 1 << IDX_BITS,
    localparam int ROW_W   = COLS * WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [IDX_BITS-1:0] load_idx,
    input  logic [ROW_W-1:0]    load_data,
    input  logic [IDX_BITS-1:0] col_idx,
    input  logic                col_wr,
    input  logic                col_rd,
    input  logic [WIDTH-1:0]    din,
    output logic [IDX_BITS-1:0] open_row,
    output logic [ROW_W-1:0]    row_data,
    output logic [WIDTH-1:0]    dout,
    output logic                dout_valid
);

    logic [WIDTH-1:0]    cell_q [COLS];
    logic [IDX_BITS-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) begin
                cell_q[c] <= '0;
            end
            row_q      <= '0;
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= col_rd;
            if (load) begin
                for (int c = 0; c < COLS; c++) begin
                    cell_q[c] <= load_data[c*WIDTH +: WIDTH];
                end
                row_q <= load_idx;
            end else if (col_wr) begin
                cell_q[col_idx] <= din;
            end
            if (col_rd) begin
                dout <= cell_q[col_idx];
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_flat
        assign row_data[c*WIDTH +: WIDTH] = cell_q[c];
    end

    assign open_row = row_q;

endmodule

// File: rtl/mux_dram_refresh.sv
// Interval counter raising refresh requests, and the rolling refresh row pointer.
module mux_dram_refresh #(
    parameter int IDX_BITS     = 2,
    parameter int REF_INTERVAL = 64,
    localparam int CNT_W       = $clog2(REF_INTERVAL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                advance,
    output logic                pending,
    output logic [IDX_BITS-1:0] ptr
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
            ptr     <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
            if (tick) begin
                pending <= 1'b1;
            end else if (start) begin
                pending <= 1'b0;
            end
            if (advance) begin
                ptr <= ptr + IDX_BITS'(1);
            end
        end
    end

endmodule

// File: rtl/mux_dram_fsm.sv
// Strobe protocol and refresh sequencing.
module mux_dram_fsm
    import mux_dram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic row_stb,
    input  logic col_stb,
    input  logic pre,
    input  logic we,
    input  logic ref_pending,
    output logic busy,
    output logic load_ext,
    output logic load_ref,
    output logic wb_open,
    output logic wb_ref,
    output logic col_rd,
    output logic col_wr,
    output logic ref_start,
    output logic proto_err
);

    dram_state_e state_q;
    dram_state_e state_d;
    logic        err_d;
    logic [1:0]  n_stb;
    logic        multi;

    assign n_stb = {1'b0, row_stb} + {1'b0, col_stb} + {1'b0, pre};
    assign multi = (n_stb > 2'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Error output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= err_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d = ST_REF_RD;
                end else if (!multi && row_stb) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (!multi && pre) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REF_RD: state_d = ST_REF_WB;
            ST_REF_WB: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        load_ext  = 1'b0;
        load_ref  = 1'b0;
        wb_open   = 1'b0;
        wb_ref    = 1'b0;
        col_rd    = 1'b0;
        col_wr    = 1'b0;
        ref_start = 1'b0;
        err_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    busy      = 1'b1;
                    ref_start = 1'b1;
                end else if (multi) begin
                    err_d = 1'b1;
                end else if (row_stb) begin
                    load_ext = 1'b1;
                end else if (col_stb) begin
                    err_d = 1'b1;
                end
            end
            ST_OPEN: begin
                if (multi || row_stb) begin
                    err_d = 1'b1;
                end else if (pre) begin
                    wb_open = 1'b1;
                end else if (col_stb) begin
                    col_wr = we;
                    col_rd = !we;
                end
            end
            ST_REF_RD: begin
                busy     = 1'b1;
                load_ref = 1'b1;
            end
            ST_REF_WB: begin
                busy   = 1'b1;
                wb_ref = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mux_dram.sv
module mux_dram #(
    parameter int IDX_BITS     = 2,
    parameter int WIDTH        = 8,
    parameter int REF_INTERVAL = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] addr,
    input  logic                row_stb,
    input  logic                col_stb,
    input  logic                we,
    input  logic                pre,
    input  logic [WIDTH-1:0]    din,
    output logic [WIDTH-1:0]    dout,
    output logic                dout_valid,
    output logic                proto_err,
    output logic                busy
);

    localparam int ROW_W = (1 << IDX_BITS) * WIDTH;

    logic                load_ext, load_ref, wb_open, wb_ref;
    logic                col_rd, col_wr, ref_start, ref_pending;
    logic [IDX_BITS-1:0] ref_ptr, open_row, rd_row, wr_row;
    logic [ROW_W-1:0]    array_rd, buf_row;

    assign rd_row = load_ref ? ref_ptr : addr;
    assign wr_row = wb_ref   ? ref_ptr : open_row;

    mux_dram_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_stb     (row_stb),
        .col_stb     (col_stb),
        .pre         (pre),
        .we          (we),
        .ref_pending (ref_pending),
        .busy        (busy),
        .load_ext    (load_ext),
        .load_ref    (load_ref),
        .wb_open     (wb_open),
        .wb_ref      (wb_ref),
        .col_rd      (col_rd),
        .col_wr      (col_wr),
        .ref_start   (ref_start),
        .proto_err   (proto_err)
    );

    mux_dram_refresh #(
        .IDX_BITS     (IDX_BITS),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ref_start),
        .advance (wb_ref),
        .pending (ref_pending),
        .ptr     (ref_ptr)
    );

    mux_dram_cells #(
        .IDX_BITS (IDX_BITS),
        .WIDTH    (WIDTH)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (rd_row),
        .rd_data (array_rd),
        .wr_en   (wb_open | wb_ref),
        .wr_row  (wr_row),
        .wr_data (buf_row)
    );

    mux_dram_rowbuf #(
        .IDX_BITS (IDX_BITS),
        .WIDTH    (WIDTH)
    ) u_rowbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ext | load_ref),
        .load_idx   (rd_row),
        .load_data  (array_rd),
        .col_idx    (addr),
        .col_wr     (col_wr),
        .col_rd     (col_rd),
        .din        (din),
        .open_row   (open_row),
        .row_data   (buf_row),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

endmodule

// File: rtl/mux_dram_checker.sv
module mux_dram_checker (
    input logic clk,
    input logic rst_n,
    input logic row_stb,
    input logic col_stb,
    input logic we,
    input logic pre,
    input logic busy,
    input logic dout_valid,
    input logic proto_err
);

    logic open_t;
    logic lone_row, lone_col, lone_pre;

    assign lone_row = row_stb && !col_stb && !pre && !busy;
    assign lone_col = col_stb && !row_stb && !pre && !busy;
    assign lone_pre = pre && !row_stb && !col_stb && !busy;

    // Port-level tracker of whether a row is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_t <= 1'b0;
        end else if (lone_row && !open_t) begin
            open_t <= 1'b1;
        end else if (lone_pre) begin
            open_t <= 1'b0;
        end
    end

    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !dout_valid);

    a_r7_col_without_row: assert property (@(posedge clk) disable iff (!rst_n)
        (lone_col && !open_t) |=> proto_err);

    a_r3_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(lone_col && !we && open_t));

    a_r10_busy_drops_col: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && col_stb) |=> (!dout_valid && !proto_err));

    a_r10_busy_drops_row: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && row_stb) |=> !proto_err);

    a_r11_busy_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !open_t);

    a_r6_close_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        lone_pre |=> !proto_err);

endmodule

bind mux_dram mux_dram_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_stb    (row_stb),
    .col_stb    (col_stb),
    .we         (we),
    .pre        (pre),
    .busy       (busy),
    .dout_valid (dout_valid),
    .proto_err  (proto_err)
);

// File: tb/mux_dram_bench.sv
module mux_dram_bench;

    localparam int IDX_BITS     = 2;
    localparam int WIDTH        = 8;
    localparam int REF_INTERVAL = 64;
    localparam int ROWS         = 1 << IDX_BITS;
    localparam int COLS         = ROWS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [IDX_BITS-1:0] addr = '0;
    logic                row_stb = 1'b0, col_stb = 1'b0, we = 1'b0, pre = 1'b0;
    logic [WIDTH-1:0]    din = '0;
    logic [WIDTH-1:0]    dout;
    logic                dout_valid, proto_err, busy;

    always #10 clk = ~clk;

    mux_dram #(
        .IDX_BITS     (IDX_BITS),
        .WIDTH        (WIDTH),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_mux_dram (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .row_stb    (row_stb),
        .col_stb    (col_stb),
        .we         (we),
        .pre        (pre),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid),
        .proto_err  (proto_err),
        .busy       (busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [WIDTH-1:0] ref_mem [ROWS][COLS];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    function automatic logic [WIDTH-1:0] pat(input int r, input int c, input int k);
        return WIDTH'(r * 53 + c * 29 + k * 71 + 7);
    endfunction

    // All tasks begin and end at a falling edge.
    task automatic clear_in();
        row_stb = 0; col_stb = 0; pre = 0; we = 0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic open_row(input int r);
        wait_ready();
        row_stb = 1; addr = IDX_BITS'(r);
        @(negedge clk);
        clear_in();
    endtask

    task automatic close_row();
        pre = 1;
        @(negedge clk);
        clear_in();
    endtask

    task automatic wr(input int c, input logic [WIDTH-1:0] d);
        col_stb = 1; we = 1; addr = IDX_BITS'(c); din = d;
        @(negedge clk);
        clear_in();
    endtask

    task automatic rd(input int c, output logic [WIDTH-1:0] d, output logic v, output logic e);
        col_stb = 1; we = 0; addr = IDX_BITS'(c);
        @(negedge clk);
        d = dout; v = dout_valid; e = proto_err;
        clear_in();
    endtask

    task automatic read_all(input string tag);
        logic [WIDTH-1:0] d;
        logic v, e;
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = COLS - 1; c >= 0; c--) begin
                rd(c, d, v, e);
                check(v && !e && d == ref_mem[r][c], tag, int'(d), int'(ref_mem[r][c]));
            end
            close_row();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        report();
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] d;
        logic v, e;
        int n;
        int busy_seen;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!dout_valid && !proto_err && !busy, "R1 reset outputs",
              {dout_valid, proto_err, busy}, 0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                ref_mem[r][c] = '0;
        read_all("R1 cell zero after reset");

        // R2 R4 R6: fill every row, then read back in reverse column order
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) begin
                wr(c, pat(r, c, 1));
                ref_mem[r][c] = pat(r, c, 1);
            end
            close_row();
        end
        read_all("R2 R4 R6 page read");

        // R3: one-cycle valid pulse
        open_row(1);
        rd(3, d, v, e);
        check(v && d == ref_mem[1][3], "R3 read data", int'(d), int'(ref_mem[1][3]));
        @(negedge clk);
        check(!dout_valid, "R3 valid single cycle", dout_valid, 0);
        close_row();

        // R5: write visible in open row, last write wins, restored after close
        open_row(2);
        wr(1, 8'hA5);
        rd(1, d, v, e);
        check(v && d == 8'hA5, "R5 read after write", int'(d), 'hA5);
        wr(1, 8'h3C);
        rd(1, d, v, e);
        check(v && d == 8'h3C, "R5 last write wins", int'(d), 'h3C);
        rd(0, d, v, e);
        check(v && d == ref_mem[2][0], "R5 neighbour untouched", int'(d), int'(ref_mem[2][0]));
        close_row();
        ref_mem[2][1] = 8'h3C;
        open_row(2);
        rd(1, d, v, e);
        check(v && d == 8'h3C, "R5 R6 write-back", int'(d), 'h3C);
        close_row();

        // R7: column strobe with no open row
        wait_ready();
        rd(2, d, v, e);
        check(e && !v, "R7 col with no row", {e, v}, 2);
        // R7: row strobe while open
        open_row(0);
        row_stb = 1; addr = 2'd3;
        @(negedge clk);
        check(proto_err && !dout_valid, "R7 row while open", {proto_err, dout_valid}, 2);
        clear_in();
        rd(0, d, v, e);
        check(v && !e && d == ref_mem[0][0], "R7 open row kept", int'(d), int'(ref_mem[0][0]));
        // R7: two strobes at once
        col_stb = 1; pre = 1; addr = 2'd2;
        @(negedge clk);
        check(proto_err && !dout_valid, "R7 double strobe", {proto_err, dout_valid}, 2);
        clear_in();
        rd(2, d, v, e);
        check(v && !e && d == ref_mem[0][2], "R7 row still open", int'(d), int'(ref_mem[0][2]));
        close_row();
        // R6: precharge with no row open
        wait_ready();
        close_row();
        check(!proto_err && !dout_valid, "R6 idle precharge", {proto_err, dout_valid}, 0);
        wait_ready();
        rd(1, d, v, e);
        check(e && !v, "R6 still closed", {e, v}, 2);

        // R8: busy length and spacing
        wait_ready();
        while (!busy) @(negedge clk);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        check(n == 3, "R8 busy length", n, 3);
        while (!busy) begin @(negedge clk); n++; end
        check(n == REF_INTERVAL, "R8 refresh spacing", n, REF_INTERVAL);

        // R10: strobes during busy ignored
        while (busy) @(negedge clk);
        while (!busy) @(negedge clk);
        col_stb = 1; addr = 2'd0;
        @(negedge clk);
        clear_in();
        check(!dout_valid && !proto_err, "R10 col in busy", {dout_valid, proto_err}, 0);
        check(busy == 1'b1, "R10 still busy", busy, 1);
        row_stb = 1; addr = 2'd1;
        @(negedge clk);
        clear_in();
        check(!dout_valid && !proto_err, "R10 row in busy", {dout_valid, proto_err}, 0);
        wait_ready();
        rd(0, d, v, e);
        check(e && !v, "R10 row not opened", {e, v}, 2);

        // R9: data survives several full refresh passes
        repeat (2 * ROWS * REF_INTERVAL + 10) @(negedge clk);
        read_all("R9 data after refresh");

        // R11: refresh deferred while row open
        open_row(3);
        busy_seen = 0;
        repeat (REF_INTERVAL + 5) begin
            if (busy) busy_seen++;
            @(negedge clk);
        end
        check(busy_seen == 0, "R11 no busy while open", busy_seen, 0);
        close_row();
        check(busy == 1'b1, "R11 refresh after close", busy, 1);
        wait_ready();
        read_all("R11 R9 data after deferred refresh");

        report();
        $finish;
    end

endmodule